// File: doc/BRIEF.md
# I2C Master SCL Ratio Generator

This block produces the clock line waveform of an I2C master from a prescaled tick that arrives as a one-cycle strobe. Each SCL period has a low phase and a high phase. Each phase has its own length, counted in ticks. A 2-bit ratio select chooses the pair of lengths. The available pairs are deliberately asymmetric, so that the low time can meet the bus minimum at higher rates. One SCL period therefore lasts the tick period times the sum of the two phase lengths.

While the enable is low, the line is released high and all counting is held at its start. When the enable is raised, the block drives SCL low at once and begins a fresh low phase. It also emits a one-cycle pulse at every low-phase start and at every high-phase start. Surrounding logic uses these pulses to shift data or to sample the bus. The select is captured only at the start of a low phase, so a new setting never shortens or stretches a phase already under way.

Top module: `scl_ratio_gen`

## Requirements
- R1: While `en` is low, `scl_o` is 1 and neither pulse output is asserted. This holds from the cycle after `en` is sampled low, and ticks have no effect.
- R2: In the cycle after `en` is first sampled high, `scl_o` is 0 and `low_start_o` is 1. This happens with or without a tick.
- R3: With `ratio_sel` = 0, the low phase lasts 4 ticks and the high phase lasts 4 ticks.
- R4: With `ratio_sel` = 1, the low phase lasts 6 ticks and the high phase lasts 3 ticks.
- R5: With `ratio_sel` = 2, the low phase lasts 11 ticks and the high phase lasts 6 ticks.
- R6: `ratio_sel` = 3 is reserved and gives the same 4:4 lengths as select 0.
- R7: `ratio_sel` is captured only when a low phase starts. A change made during a phase affects neither that phase nor the high phase that follows it. The new value applies from the next low-phase start.
- R8: `low_start_o` is one cycle wide and coincides with the 1-to-0 step of `scl_o`. `high_start_o` is one cycle wide and coincides with the 0-to-1 step of `scl_o`.
- R9: Phase counting advances only on cycles where `tick` is 1. Without ticks, `scl_o` holds its level and no pulse is emitted.
- R10: If `en` is dropped in the middle of a phase and raised again, a complete low phase of the currently selected length starts anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low releases SCL |
| tick | input | 1 | One-cycle prescaled time strobe |
| ratio_sel | input | 2 | Low:high ratio choice (0:4:4, 1:6:3, 2:11:6, 3:as 0) |
| scl_o | output | 1 | SCL drive level (1 = released) |
| low_start_o | output | 1 | Pulse at the start of each low phase |
| high_start_o | output | 1 | Pulse at the start of each high phase |

## Verification
A corrupted phase counter or a wrong captured select shows up as a phase of the wrong tick length. The bench measures this between consecutive pulses, so a fault is reported within one SCL period. A flipped phase flag shows as a pulse that does not line up with an SCL edge. The checker flags that in the same cycle. A missed restart on enable shows as an absent low-start pulse one cycle after `en` rises.

// File: rtl/scl_ratio_gen.sv
module scl_ratio_gen #(
  parameter int CNT_W  = 4,
  parameter int LOW_0  = 4,
  parameter int HIGH_0 = 4,
  parameter int LOW_1  = 6,
  parameter int HIGH_1 = 3,
  parameter int LOW_2  = 11,
  parameter int HIGH_2 = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic [1:0] ratio_sel,
  output logic       scl_o,
  output logic       low_start_o,
  output logic       high_start_o
);

  logic             running;
  logic             in_high;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] low_last(input logic [1:0] s);
    case (s)
      2'd1:    return CNT_W'(LOW_1 - 1);
      2'd2:    return CNT_W'(LOW_2 - 1);
      default: return CNT_W'(LOW_0 - 1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] high_last(input logic [1:0] s);
    case (s)
      2'd1:    return CNT_W'(HIGH_1 - 1);
      2'd2:    return CNT_W'(HIGH_2 - 1);
      default: return CNT_W'(HIGH_0 - 1);
    endcase
  endfunction

  wire end_low  = !in_high && (cnt == low_last(sel_q));
  wire end_high =  in_high && (cnt == high_last(sel_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running      <= 1'b0;
      in_high      <= 1'b0;
      sel_q        <= 2'd0;
      cnt          <= '0;
      scl_o        <= 1'b1;
      low_start_o  <= 1'b0;
      high_start_o <= 1'b0;
    end else begin
      low_start_o  <= 1'b0;
      high_start_o <= 1'b0;
      if (!en) begin
        running <= 1'b0;
        in_high <= 1'b0;
        cnt     <= '0;
        scl_o   <= 1'b1;
      end else if (!running) begin
        running     <= 1'b1;
        in_high     <= 1'b0;
        cnt         <= '0;
        scl_o       <= 1'b0;
        low_start_o <= 1'b1;
        sel_q       <= ratio_sel;
      end else if (tick) begin
        if (end_low) begin
          in_high      <= 1'b1;
          cnt          <= '0;
          scl_o        <= 1'b1;
          high_start_o <= 1'b1;
        end else if (end_high) begin
          in_high     <= 1'b0;
          cnt         <= '0;
          scl_o       <= 1'b0;
          low_start_o <= 1'b1;
          sel_q       <= ratio_sel;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/scl_ratio_gen_chk.sv
module scl_ratio_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic tick,
  input logic scl_o,
  input logic low_start_o,
  input logic high_start_o
);

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_o && !low_start_o && !high_start_o));

  a_r2_enable_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> (low_start_o && !scl_o));

  a_r8_low_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    low_start_o |-> (!scl_o && $past(scl_o)));

  a_r8_high_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    high_start_o |-> (scl_o && !$past(scl_o)));

  a_r8_single_low_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    low_start_o |=> !low_start_o);

  a_r8_single_high_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    high_start_o |=> !high_start_o);

  a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_start_o, high_start_o}));

  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !tick) |=> ($stable(scl_o) && !low_start_o && !high_start_o));

endmodule

bind scl_ratio_gen scl_ratio_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
  .scl_o(scl_o), .low_start_o(low_start_o), .high_start_o(high_start_o)
);

// File: tb/scl_ratio_gen_tb.sv
module scl_ratio_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] ratio_sel = 2'd0;
  logic       scl_o, low_start_o, high_start_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scl_ratio_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .ratio_sel(ratio_sel),
    .scl_o(scl_o), .low_start_o(low_start_o), .high_start_o(high_start_o)
  );

  function automatic int exp_low(input logic [1:0] s);
    case (s)
      2'd1: return 6;
      2'd2: return 11;
      default: return 4;
    endcase
  endfunction

  function automatic int exp_high(input logic [1:0] s);
    case (s)
      2'd1: return 3;
      2'd2: return 6;
      default: return 4;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] s);
    case (s)
      2'd1: return "R4";
      2'd2: return "R5";
      2'd3: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit t);
    @(negedge clk);
    tick = t;
    @(posedge clk);
    #1;
  endtask

  function automatic bit rnd_tick();
    return ($urandom % 3) == 0;
  endfunction

  // Called just after a low_start has been observed; cur is the captured select.
  task automatic measure(input logic [1:0] cur, input logic [1:0] nxt, input string tag);
    int lo = 0;
    int hi = 0;
    int guard = 0;
    bit bad = 0;
    bit t;
    bit changed = 0;
    while (guard < 2000) begin
      t = rnd_tick();
      step(t);
      guard++;
      if (t) lo++;
      if (lo >= 1 && !changed) begin ratio_sel = nxt; changed = 1; end
      if (high_start_o) break;
      if (scl_o !== 1'b0 || low_start_o) bad = 1;
    end
    chk(!bad, "R8", bad, 0);
    chk(lo == exp_low(cur), tag, lo, exp_low(cur));
    chk(scl_o === 1'b1, "R8", scl_o, 1);
    guard = 0;
    bad = 0;
    while (guard < 2000) begin
      t = rnd_tick();
      step(t);
      guard++;
      if (t) hi++;
      if (low_start_o) break;
      if (scl_o !== 1'b1 || high_start_o) bad = 1;
    end
    chk(!bad, "R8", bad, 0);
    chk(hi == exp_high(cur), tag, hi, exp_high(cur));
    chk(scl_o === 1'b0, "R8", scl_o, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0] cur;
    logic [1:0] nxt;
    bit quiet;
    void'($urandom(32'h5c1a_0417));
    repeat (3) @(posedge clk);
    #1;
    chk(scl_o === 1'b1 && !low_start_o && !high_start_o, "R1 reset", scl_o, 1);
    @(negedge clk);
    rst_n = 1'b1;
    quiet = 1;
    for (int i = 0; i < 10; i++) begin
      step(1'b1);
      if (scl_o !== 1'b1 || low_start_o || high_start_o) quiet = 0;
    end
    chk(quiet, "R1 idle ticks", quiet, 1);

    // R2 enable without tick
    ratio_sel = 2'd0;
    en = 1'b1;
    step(1'b0);
    chk(low_start_o && scl_o === 1'b0, "R2", {low_start_o, scl_o}, 2);

    // R9 no ticks hold
    quiet = 1;
    for (int i = 0; i < 30; i++) begin
      step(1'b0);
      if (scl_o !== 1'b0 || low_start_o || high_start_o) quiet = 0;
    end
    chk(quiet, "R9", quiet, 1);

    // R3, then R7: change to 2 mid-phase; current period stays 4:4
    measure(2'd0, 2'd2, "R3 R7 old kept");
    measure(2'd2, 2'd1, "R5 R7 new applied");
    measure(2'd1, 2'd3, "R4");
    measure(2'd3, 2'd2, "R6");

    // R10 disable mid low phase
    for (int i = 0; i < 3; i++) step(1'b1);
    en = 1'b0;
    step(1'b1);
    chk(scl_o === 1'b1 && !low_start_o && !high_start_o, "R1 R10 drop", scl_o, 1);
    quiet = 1;
    for (int i = 0; i < 8; i++) begin
      step(1'b1);
      if (scl_o !== 1'b1 || low_start_o || high_start_o) quiet = 0;
    end
    chk(quiet, "R1 disabled", quiet, 1);
    ratio_sel = 2'd1;
    en = 1'b1;
    step(1'b1);
    chk(low_start_o && scl_o === 1'b0, "R10 restart", {low_start_o, scl_o}, 2);
    cur = 2'd1;

    // Random periods
    for (int k = 0; k < 40; k++) begin
      nxt = 2'($urandom % 4);
      measure(cur, nxt, req_of(cur));
      cur = nxt;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule